// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block sits between a wide bus of pad input signals and a downstream interrupt controller that only accepts active-high levels or rising edges. It has eight interrupt output channels. Each channel picks one pad through its own 8-bit index. The picked pad is synchronised and can optionally be debounced. It can then be inverted, and it is finally shaped into either a level or a one-clock pulse. The number of pads actually wired is a parameter, for example 110, 119 or 133. An index at or beyond that count selects a constant zero.

Software sets the block up through four 32-bit registers, addressed by a 2-bit word index. Index 0 (byte offset 0x00) holds the sense settings: bit n selects edge mode for channel n, and bit 16+n selects low polarity for channel n. Index 1 (0x04) holds the pad indices for channels 0 to 3, and index 2 (0x08) holds them for channels 4 to 7. In both, channel n uses bits (n mod 4)*8 +: 8. Index 3 (0x0C) holds a 4-bit debounce length per channel at bits n*4 +: 4. Writes take effect on the clock edge, and reads are combinational.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset all four registers read as zero and every interrupt output is low.
- R2: A written register reads back its written value, except that in the sense register (index 0) only bits 7:0 and 23:16 are stored, and all other bits read as zero.
- R3: Channel n takes its pad index from bits (n mod 4)*8 +: 8 of register index 1 (channels 0-3) or index 2 (channels 4-7).
- R4: In level mode with polarity high and debounce 0, a channel output follows its selected pad with a latency of exactly three clock edges.
- R5: Setting the low-polarity bit (bit 16+n) inverts the selected pad, so in level mode the output is high while the pad is low.
- R6: In edge mode (bit n set) with polarity high, each rising transition of the pad gives a one-clock output pulse three edges later, and a falling transition gives no pulse.
- R7: In edge mode with low polarity, each falling transition gives a one-clock pulse and a rising transition gives none; only one edge direction is ever sensed.
- R8: A pad index at or above the wired pad count reads as constant zero, while index count-1 is routed normally.
- R9: A nonzero debounce value D (bits n*4 +: 4 of register index 3) requires the synchronised pad to differ from the filtered value for 8*D consecutive cycles before the filtered value changes, so the latency is 2+8*D edges and shorter pulses are dropped. A value of 0 bypasses the filter.
- R10: Channels are independent: a pad change affects only the channels that select that pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index (0..3) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| pad_in | input | N_PADS | Pad input signals |
| irq_out | output | 8 | Active-high interrupt outputs, one per channel |

## Verification
The bench pins the exact edge on which a level output changes. A design with one synchroniser flop too few or too many would be caught by the cycle-accurate sampling. Edge tests check for a pulse on one direction only, and check that the pulse lasts one cycle. A design that detects both edges, or that stretches the pulse, would fail there. The boundary index equal to the pad count must read zero, while the index just below it must route. An off-by-one range test would flip one of these two. The debounce test samples one cycle before and one cycle at 2+8*D edges, and checks that a 10-cycle glitch is dropped. A counter that counts N or 8N-1 cycles, or that does not restart on a glitch, would show a shifted or spurious output.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NUM_CH   = 8;
  localparam int SEL_W    = 8;
  localparam int FILT_W   = 4;
  localparam int CNT_W    = FILT_W + 3;
  localparam int REG_W    = 32;
  localparam int CH_PER_W = REG_W / SEL_W;

  typedef enum logic [1:0] {
    RIDX_SENSE = 2'd0,
    RIDX_SELLO = 2'd1,
    RIDX_SELHI = 2'd2,
    RIDX_FILT  = 2'd3
  } reg_idx_e;

  localparam logic [REG_W-1:0] SENSE_MASK = 32'h00FF_00FF;
endpackage

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [1:0]                         addr,
  input  logic [REG_W-1:0]                   wdata,
  output logic [REG_W-1:0]                   rdata,
  output logic [NUM_CH-1:0]                  edge_mode,
  output logic [NUM_CH-1:0]                  low_pol,
  output logic [NUM_CH-1:0][SEL_W-1:0]       sel_idx,
  output logic [NUM_CH-1:0][FILT_W-1:0]      filt_len
);
  logic [REG_W-1:0] sense_q, sense_n;
  logic [REG_W-1:0] sello_q, sello_n;
  logic [REG_W-1:0] selhi_q, selhi_n;
  logic [REG_W-1:0] filt_q,  filt_n;

  always_comb begin
    sense_n = sense_q;
    sello_n = sello_q;
    selhi_n = selhi_q;
    filt_n  = filt_q;
    if (wr_en) begin
      case (reg_idx_e'(addr))
        RIDX_SENSE: sense_n = wdata & SENSE_MASK;
        RIDX_SELLO: sello_n = wdata;
        RIDX_SELHI: selhi_n = wdata;
        default:    filt_n  = wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      sello_q <= '0;
      selhi_q <= '0;
      filt_q  <= '0;
    end else begin
      sense_q <= sense_n;
      sello_q <= sello_n;
      selhi_q <= selhi_n;
      filt_q  <= filt_n;
    end
  end

  always_comb begin
    case (reg_idx_e'(addr))
      RIDX_SENSE: rdata = sense_q & SENSE_MASK;
      RIDX_SELLO: rdata = sello_q;
      RIDX_SELHI: rdata = selhi_q;
      default:    rdata = filt_q;
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
    assign edge_mode[c] = sense_q[c];
    assign low_pol[c]   = sense_q[16 + c];
    assign filt_len[c]  = filt_q[c*FILT_W +: FILT_W];
    if (c < CH_PER_W) begin : g_lo
      assign sel_idx[c] = sello_q[c*SEL_W +: SEL_W];
    end else begin : g_hi
      assign sel_idx[c] = selhi_q[(c-CH_PER_W)*SEL_W +: SEL_W];
    end
  end

  // R2: unused sense bits never read back as set
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[15:8] == 8'h00 && rdata[31:24] == 8'h00));
endmodule

// File: rtl/gir_filter.sv
module gir_filter
  import gir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] len,
  output logic              dout
);
  logic             dout_q, dout_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] limit;

  assign limit = {len, 3'b000} - CNT_W'(1);

  always_comb begin
    dout_n = dout_q;
    cnt_n  = '0;
    if (len == '0) begin
      dout_n = din;
    end else if (din != dout_q) begin
      if (cnt_q >= limit) begin
        dout_n = din;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      dout_q <= dout_n;
      cnt_q  <= cnt_n;
    end
  end

  assign dout = dout_q;

  // R9: counter stays within the programmed window
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0 && $stable(len)) |-> (cnt_q <= limit));
  // R9: a filtered change only after a full window
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_q != $past(dout_q)) && $past(len) != '0) |-> ($past(cnt_q) >= $past(limit)));
  // R4: bypass passes the input with one register of delay
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0 && $past(len) == '0) |-> (dout_q == $past(din)));
endmodule

// File: rtl/gir_channel.sv
module gir_channel
  import gir_pkg::*;
#(
  parameter int N_PADS = 133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PADS-1:0] pad_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              edge_mode,
  input  logic              low_pol,
  input  logic [FILT_W-1:0] filt_len,
  output logic              irq
);
  logic pick;
  logic sync1_q, sync2_q;
  logic filt;
  logic sensed, sensed_d_q;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < N_PADS; i++) begin
      if (sel == i[SEL_W-1:0]) pick = pad_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pick;
      sync2_q <= sync1_q;
    end
  end

  gir_filter u_filter (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sync2_q),
    .len  (filt_len),
    .dout (filt)
  );

  assign sensed = filt ^ low_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sensed_d_q <= 1'b0;
    else        sensed_d_q <= sensed;
  end

  assign irq = edge_mode ? (sensed & ~sensed_d_q) : sensed;

  // R6: an edge event lasts exactly one cycle
  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && $past(edge_mode) && $stable(low_pol) && $stable(filt_len) && $past(irq)) |-> !irq);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int N_PADS = 133
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_PADS-1:0] pad_in,
  output logic [7:0]        irq_out
);
  logic [NUM_CH-1:0]             edge_mode;
  logic [NUM_CH-1:0]             low_pol;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel_idx;
  logic [NUM_CH-1:0][FILT_W-1:0] filt_len;

  gir_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .edge_mode(edge_mode),
    .low_pol  (low_pol),
    .sel_idx  (sel_idx),
    .filt_len (filt_len)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gir_channel #(.N_PADS(N_PADS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pad_in   (pad_in),
      .sel      (sel_idx[c]),
      .edge_mode(edge_mode[c]),
      .low_pol  (low_pol[c]),
      .filt_len (filt_len[c]),
      .irq      (irq_out[c])
    );
  end

  // R1: outputs are quiet in the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_out == 8'h00));
endmodule

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 133;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [7:0]    irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  gpio_irq_router #(.N_PADS(NP)) u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic cfg(input logic [31:0] sense, input logic [31:0] slo,
                     input logic [31:0] shi, input logic [31:0] flt);
    wr(2'd0, sense); wr(2'd1, slo); wr(2'd2, shi); wr(2'd3, flt);
    step(40);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) rd_check("R1 reg", 2'(a), 32'h0);
    check("R1 irq", {24'h0, irq_out}, 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R2 sense mask", 2'd0, 32'h00FF_00FF);
    wr(2'd1, 32'hA5C3_1E77); rd_check("R2 sel lo", 2'd1, 32'hA5C3_1E77);
    wr(2'd2, 32'h0F1E_2D3C); rd_check("R2 sel hi", 2'd2, 32'h0F1E_2D3C);
    wr(2'd3, 32'h8765_4321); rd_check("R2 filt", 2'd3, 32'h8765_4321);
    rd_check("R2 sense kept", 2'd0, 32'h00FF_00FF);
  endtask

  // ch0 -> pad 5 (index 1 bits 7:0), ch5 -> pad 130 (index 2 bits 15:8), level high
  task automatic t_level();
    pad_in = '0;
    cfg(32'h0, 32'h0000_0005, 32'h0000_8200, 32'h0);
    pad_in[5] = 1'b1;
    step(2); check("R4 before latency", {24'h0, irq_out}, 32'h00);
    step(1); check("R4 at latency", {24'h0, irq_out}, 32'h01);
    check("R10 only ch0", {24'h0, irq_out}, 32'h01);
    pad_in[130] = 1'b1;
    step(3); check("R3 ch5 field", {24'h0, irq_out}, 32'h21);
    pad_in[5] = 1'b0;
    step(3); check("R4 follows low", {24'h0, irq_out}, 32'h20);
    pad_in[130] = 1'b0;
    step(3);
  endtask

  task automatic t_invert();
    pad_in = '0;
    cfg(32'h0001_0000, 32'h0000_0005, 32'h0, 32'h0);
    check("R5 low pad high out", {31'h0, irq_out[0]}, 32'h1);
    pad_in[5] = 1'b1;
    step(3); check("R5 high pad low out", {31'h0, irq_out[0]}, 32'h0);
  endtask

  // ch1 -> pad 7 (index 1 bits 15:8)
  task automatic t_edge_rise();
    pad_in = '0;
    cfg(32'h0000_0002, 32'h0000_0700, 32'h0, 32'h0);
    check("R6 idle", {31'h0, irq_out[1]}, 32'h0);
    pad_in[7] = 1'b1;
    step(2); check("R6 before pulse", {31'h0, irq_out[1]}, 32'h0);
    step(1); check("R6 pulse", {31'h0, irq_out[1]}, 32'h1);
    step(1); check("R6 one cycle", {31'h0, irq_out[1]}, 32'h0);
    pad_in[7] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step(1); check("R6 no fall pulse", {31'h0, irq_out[1]}, 32'h0);
    end
  endtask

  task automatic t_edge_fall();
    pad_in = '0;
    cfg(32'h0002_0002, 32'h0000_0700, 32'h0, 32'h0);
    pad_in[7] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1); check("R7 no rise pulse", {31'h0, irq_out[1]}, 32'h0);
    end
    pad_in[7] = 1'b0;
    step(2); check("R7 before pulse", {31'h0, irq_out[1]}, 32'h0);
    step(1); check("R7 fall pulse", {31'h0, irq_out[1]}, 32'h1);
    step(1); check("R7 one cycle", {31'h0, irq_out[1]}, 32'h0);
  endtask

  // ch2 -> 200, ch3 -> 133, ch4 -> 132
  task automatic t_range();
    pad_in = '0;
    cfg(32'h0, 32'h85C8_0000, 32'h0000_0084, 32'h0);
    pad_in = '1;
    step(3);
    check("R8 index 200 zero", {31'h0, irq_out[2]}, 32'h0);
    check("R8 index 133 zero", {31'h0, irq_out[3]}, 32'h0);
    check("R8 index 132 routed", {31'h0, irq_out[4]}, 32'h1);
    cfg(32'h0004_0000, 32'h85C8_0000, 32'h0000_0084, 32'h0);
    check("R8 inverted zero", {31'h0, irq_out[2]}, 32'h1);
    pad_in = '0;
    step(3);
  endtask

  // ch0 -> pad 5, debounce 2 (16 cycles)
  task automatic t_filter();
    pad_in = '0;
    cfg(32'h0, 32'h0000_0005, 32'h0, 32'h0000_0002);
    pad_in[5] = 1'b1;
    step(17); check("R9 before window", {31'h0, irq_out[0]}, 32'h0);
    step(1);  check("R9 at window", {31'h0, irq_out[0]}, 32'h1);
    step(5);
    pad_in[5] = 1'b0;
    step(10);
    pad_in[5] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step(6); check("R9 glitch dropped", {31'h0, irq_out[0]}, 32'h1);
    end
    pad_in[5] = 1'b0;
    step(17); check("R9 fall before window", {31'h0, irq_out[0]}, 32'h1);
    step(1);  check("R9 fall at window", {31'h0, irq_out[0]}, 32'h0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_level();
    t_invert();
    t_edge_rise();
    t_edge_fall();
    t_range();
    t_filter();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule